// File: doc/BRIEF.md
# Edge-Serviced Watchdog Timer

This block watches a processor's health through a single service line. Software proves it is alive by toggling that line, and either a rising or a falling edge counts as service. If the line stays at one level for a parameterised number of clock cycles, an active-low watchdog flag drops. The flag then stays low until the line toggles again.

The flag is also forced low whenever the supply-good input is deasserted. When the supply recovers, the flag releases in the same cycle, without waiting for any stretch. While the external reset generator reports reset active, the timeout counter is held at zero and any pending timeout is cleared. This allows the flag to be looped back into a manual-reset request, which produces a periodic reset when software has stopped servicing the line. An enable input stands in for a disconnected service line. When it is low, the counter is held at zero and the flag follows only the supply condition.

Top module: `wdt_edge_top`

## Requirements
- R1: After the counter starts from zero, a timeout occurs on the TWD_CYCLES-th consecutive clock edge at which the counter was not cleared. After that edge the flag `wd_n_o` reads 0 (with the supply good), and not one edge earlier.
- R2: A rising edge and a falling edge of `svc_i` both clear the counter and any pending timeout. The edge is seen at the first clock edge that samples the new level, and the flag reads 1 after that clock edge.
- R3: While `rst_active_i` is 1, the counter is held at 0 and a pending timeout is cleared, so the flag reads 1 one clock after reset-active is sampled. Counting restarts at the first clock edge that samples `rst_active_i` low, and the timeout then follows R1.
- R4: Once a timeout has occurred, the flag stays 0 for as long as there is no transition on `svc_i`, the block is enabled and reset-active is low. This holds even if the supply dips and recovers in the meantime.
- R5: When `supply_ok_i` is 0, `wd_n_o` is 0 in the same cycle, whatever the state of the timer.
- R6: When `supply_ok_i` returns to 1 and no timeout is pending, `wd_n_o` returns to 1 in the same cycle, with no delay.
- R7: The flag can be looped into a reset generator that samples it on each clock and asserts reset-active one cycle after seeing it low. That generator then holds reset-active for STRETCH further cycles after the flag is seen high. With `svc_i` stuck, the flag falls every TWD_CYCLES + STRETCH + 2 cycles and stays low for 2 cycles each time.
- R8: While `wd_en_i` is 0, the counter is held at 0 and no timeout occurs, so `wd_n_o` equals `supply_ok_i`. After re-enabling, the timeout follows R1 starting from zero.
- R9: A pulse on `svc_i` one clock cycle wide produces two services, one on each of its edges. The timeout then counts from the second edge.
- R10: While `rst` is high, the counter is 0, no timeout is pending and the flag reads 1 with the supply good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| svc_i | input | 1 | Service line, already synchronised; either edge services |
| wd_en_i | input | 1 | Watchdog enable; 0 models a disconnected service line |
| supply_ok_i | input | 1 | Supply above threshold when 1 |
| rst_active_i | input | 1 | Reset asserted by the external reset generator |
| wd_n_o | output | 1 | Active-low watchdog flag |

## Verification
The assertions assume that `svc_i` and the other control inputs are synchronous to `clk` and change only between clock edges. They also assume that the block reset is high from the first edge, so the edge detector and the checker's own copy of the previous service level start from the same value. The bench keeps to these assumptions by driving every input one time unit after a rising edge and by holding reset from time zero. In the loop test, reset-active comes from a clocked generator model, so that input also moves only after a clock edge.

// File: rtl/wdt_edge_pkg.sv
package wdt_edge_pkg;

    // Edge events seen on the service line in one clock cycle
    typedef struct packed {
        logic rise;
        logic fall;
    } svc_edge_t;

    // Timer condition
    typedef enum logic {
        WD_ARMED   = 1'b0,
        WD_TRIPPED = 1'b1
    } wd_state_e;

    // Bits needed to hold the values 0 .. limit
    function automatic int cnt_bits(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/wdt_edge_det.sv
module wdt_edge_det
    import wdt_edge_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      svc_i,
    output svc_edge_t edge_o
);

    logic svc_q;

    always_ff @(posedge clk) begin
        if (rst) svc_q <= 1'b0;
        else     svc_q <= svc_i;
    end

    // Compare the current level with the level registered one cycle earlier
    always_comb begin
        edge_o.rise = svc_i & ~svc_q;
        edge_o.fall = ~svc_i & svc_q;
    end

endmodule

// File: rtl/wdt_edge_timer.sv
module wdt_edge_timer
    import wdt_edge_pkg::*;
#(
    parameter int TWD_CYCLES = 80_000_000,
    parameter int CW         = cnt_bits(TWD_CYCLES)
) (
    input  logic          clk,
    input  logic          rst,
    input  svc_edge_t     edge_i,
    input  logic          en_i,
    input  logic          rst_active_i,
    output logic [CW-1:0] cnt_o,
    output logic          tripped_o
);

    localparam logic [CW-1:0] CNT_LAST = CW'(TWD_CYCLES - 1);
    localparam logic [CW-1:0] CNT_SAT  = CW'(TWD_CYCLES);

    logic [CW-1:0] cnt_q;
    wd_state_e     st_q;
    logic          hold;
    logic          clear;

    // Disabled or under reset: counter frozen at zero
    assign hold  = rst_active_i | ~en_i;
    assign clear = hold | edge_i.rise | edge_i.fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            st_q  <= WD_ARMED;
        end else if (clear) begin
            cnt_q <= '0;
            st_q  <= WD_ARMED;
        end else if (st_q == WD_ARMED) begin
            if (cnt_q == CNT_LAST) begin
                cnt_q <= CNT_SAT;
                st_q  <= WD_TRIPPED;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt_o     = cnt_q;
    assign tripped_o = (st_q == WD_TRIPPED);

endmodule

// File: rtl/wdt_edge_flag.sv
module wdt_edge_flag (
    input  logic tripped_i,
    input  logic supply_ok_i,
    output logic wd_n_o
);

    // Supply loss forces the flag at once; recovery releases it at once
    assign wd_n_o = supply_ok_i & ~tripped_i;

endmodule

// File: rtl/wdt_edge_top.sv
module wdt_edge_top
    import wdt_edge_pkg::*;
#(
    parameter int TWD_CYCLES = 80_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic svc_i,
    input  logic wd_en_i,
    input  logic supply_ok_i,
    input  logic rst_active_i,
    output logic wd_n_o
);

    localparam int CW = cnt_bits(TWD_CYCLES);

    svc_edge_t     edge_w;
    logic [CW-1:0] cnt_w;
    logic          tripped_w;

    wdt_edge_det u_det (
        .clk    (clk),
        .rst    (rst),
        .svc_i  (svc_i),
        .edge_o (edge_w)
    );

    wdt_edge_timer #(
        .TWD_CYCLES (TWD_CYCLES),
        .CW         (CW)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .edge_i       (edge_w),
        .en_i         (wd_en_i),
        .rst_active_i (rst_active_i),
        .cnt_o        (cnt_w),
        .tripped_o    (tripped_w)
    );

    wdt_edge_flag u_flag (
        .tripped_i   (tripped_w),
        .supply_ok_i (supply_ok_i),
        .wd_n_o      (wd_n_o)
    );

endmodule

// File: rtl/wdt_edge_chk.sv
module wdt_edge_chk #(
    parameter int TWD = 16,
    parameter int CW  = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          svc_i,
    input logic          wd_en_i,
    input logic          supply_ok_i,
    input logic          rst_active_i,
    input logic          wd_n_o,
    input logic [CW-1:0] cnt,
    input logic          tripped
);

    logic svc_prev;
    logic svc_moved;

    always_ff @(posedge clk) begin
        if (rst) svc_prev <= 1'b0;
        else     svc_prev <= svc_i;
    end

    assign svc_moved = (svc_i != svc_prev);

    // R1: trip happens only from the last count value, never beyond the limit
    a_r1_trip_at_limit: assert property (@(posedge clk) disable iff (rst)
        $rose(tripped) |-> ($past(cnt) == CW'(TWD - 1)));
    a_r1_no_overrun: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(TWD));

    // R2: either edge polarity clears the counter and the timeout
    a_r2_edge_clears: assert property (@(posedge clk) disable iff (rst)
        svc_moved |=> (cnt == '0) && !tripped);

    // R3: reset-active freezes the counter at zero and releases the flag
    a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
        rst_active_i |=> (cnt == '0) && !tripped);
    a_r3_flag_high: assert property (@(posedge clk) disable iff (rst)
        ($past(rst_active_i) && supply_ok_i) |-> wd_n_o);

    // R4: timeout is sticky until serviced
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        (tripped && !svc_moved && wd_en_i && !rst_active_i) |=> tripped);

    // R5: supply loss forces the flag low
    a_r5_supply_low: assert property (@(posedge clk) disable iff (rst)
        !supply_ok_i |-> !wd_n_o);

    // R8: disable holds the timer cleared
    a_r8_disabled: assert property (@(posedge clk) disable iff (rst)
        !wd_en_i |=> (cnt == '0) && !tripped);

endmodule

bind wdt_edge_top wdt_edge_chk #(
    .TWD (TWD_CYCLES),
    .CW  (CW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .svc_i        (svc_i),
    .wd_en_i      (wd_en_i),
    .supply_ok_i  (supply_ok_i),
    .rst_active_i (rst_active_i),
    .wd_n_o       (wd_n_o),
    .cnt          (cnt_w),
    .tripped      (tripped_w)
);

// File: tb/wdt_edge_top_tb_top.sv
`timescale 1ns/1ps
module wdt_edge_top_tb_top;

    localparam int TWD     = 16;
    localparam int STRETCH = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic svc = 1'b0;
    logic en = 1'b1;
    logic sup = 1'b1;
    logic tb_ra = 1'b0;
    logic loop_on = 1'b0;
    logic gen_act = 1'b0;
    int   gen_st = 0;
    logic ra_w;
    logic wd_n;
    logic done = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    assign ra_w = loop_on ? gen_act : tb_ra;

    wdt_edge_top #(.TWD_CYCLES(TWD)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .svc_i        (svc),
        .wd_en_i      (en),
        .supply_ok_i  (sup),
        .rst_active_i (ra_w),
        .wd_n_o       (wd_n)
    );

    // Reset generator model: flag looped into its manual-reset request
    always @(posedge clk) begin
        if (!loop_on) begin
            gen_st  <= 0;
            gen_act <= 1'b0;
        end else if (!wd_n) begin
            gen_act <= 1'b1;
            gen_st  <= STRETCH;
        end else if (gen_st > 1) begin
            gen_st <= gen_st - 1;
        end else begin
            gen_st  <= 0;
            gen_act <= 1'b0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Counter starts counting at the next edge; trip exactly on the TWD-th
    task automatic expect_trip(input string req);
        for (int k = 1; k <= TWD; k++) begin
            step();
            chk(req, int'(wd_n), (k < TWD) ? 1 : 0);
        end
    endtask

    // Toggle the service line; the next edge clears the timer
    task automatic service(input string req);
        svc = ~svc;
        step();
        chk(req, int'(wd_n), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int falls[4];
        int rises[4];
        int nf;
        int nr;
        logic prev;

        // R10: reset state
        repeat (3) step();
        chk("R10 reset flag", int'(wd_n), 1);
        rst = 1'b0;

        // R1: timeout from release of block reset
        expect_trip("R1 first timeout");

        // R4: sticky while unserviced
        for (int k = 0; k < 2 * TWD; k++) begin
            step();
            chk("R4 sticky", int'(wd_n), 0);
        end

        // R2: rising edge, then falling edge
        service("R2 rising edge");
        expect_trip("R1 after rise");
        service("R2 falling edge");
        expect_trip("R1 after fall");

        // R2: re-service at every offset inside the window
        for (int off = 1; off < TWD; off++) begin
            service("R2 sweep clear");
            for (int k = 1; k <= off; k++) begin
                step();
                chk("R2 sweep high", int'(wd_n), 1);
            end
            service("R2 sweep reservice");
            expect_trip("R1 sweep trip");
        end

        // R9: one-cycle pulse gives two services
        svc = ~svc;
        step();
        chk("R9 pulse first edge", int'(wd_n), 1);
        svc = ~svc;
        step();
        chk("R9 pulse second edge", int'(wd_n), 1);
        expect_trip("R9 count from second edge");

        // R3: freeze during reset-active, restart on release
        service("R3 pre-service");
        for (int k = 0; k < TWD / 2; k++) step();
        tb_ra = 1'b1;
        for (int k = 0; k < 3 * TWD; k++) begin
            step();
            chk("R3 frozen", int'(wd_n), 1);
        end
        tb_ra = 1'b0;
        expect_trip("R3 restart");
        tb_ra = 1'b1;
        step();
        chk("R3 clears timeout", int'(wd_n), 1);
        tb_ra = 1'b0;
        expect_trip("R3 restart after clear");

        // R5 / R6: supply forcing
        service("R5 pre-service");
        sup = 1'b0;
        #1;
        chk("R5 immediate low", int'(wd_n), 0);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R5 held low", int'(wd_n), 0);
        end
        sup = 1'b1;
        #1;
        chk("R6 immediate release", int'(wd_n), 1);
        service("R6 re-service");
        expect_trip("R1 after supply test");
        sup = 1'b0;
        step();
        sup = 1'b1;
        #1;
        chk("R4 sticky across supply dip", int'(wd_n), 0);

        // R8: disable
        en = 1'b0;
        step();
        chk("R8 disable clears", int'(wd_n), 1);
        for (int k = 0; k < 3 * TWD; k++) begin
            step();
            chk("R8 no timeout", int'(wd_n), 1);
        end
        sup = 1'b0;
        #1;
        chk("R8 follows supply low", int'(wd_n), 0);
        sup = 1'b1;
        #1;
        chk("R8 follows supply high", int'(wd_n), 1);
        en = 1'b1;
        expect_trip("R8 re-enable");

        // R7: looped periodic reset with stuck service line
        service("R7 pre-service");
        loop_on = 1'b1;
        nf = 0;
        nr = 0;
        prev = wd_n;
        for (int t = 1; t <= 400 && nf < 4; t++) begin
            step();
            if (prev && !wd_n) begin falls[nf] = t; nf++; end
            if (!prev && wd_n && nr < 4) begin rises[nr] = t; nr++; end
            prev = wd_n;
        end
        chk("R7 fall count", nf, 4);
        for (int i = 1; i < 4; i++)
            chk("R7 period", falls[i] - falls[i-1], TWD + STRETCH + 2);
        for (int i = 0; i < 3; i++)
            chk("R7 low width", rises[i] - falls[i], 2);
        loop_on = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule